// File: doc/BRIEF.md
# Multiplexed Status Output Pin Controller

This block decides, every system clock, whether a single open-drain status pin is pulled low or left floating. A 3-bit select input picks the source shown on the pin: nothing (pin floats), the loop-unlock flag, a sticky "frequency count finished" flag, or the level of one of two shared general-purpose pins. The block's only output is a pull-low enable for an open-drain pad.

A serial host port can take the pin over. While its chip-enable is high for a write transfer, the pin floats. While chip-enable is high for a read transfer, the pin carries the serial read data bit, updated on each rising edge of the serial clock. Chip-enable and serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer before the block looks for edges. All control and status pins are plain levels: no data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

The count-finished flag is set by a one-cycle pulse from the frequency counter. It is cleared when a new count starts (count-enable rises) or when a serial access begins (synchronized chip-enable rises).

Top module: `status_pin_ctrl`

## Requirements
- R1: After reset is released, and before any input is applied, pull_low_o is 0 (pin open).
- R2: With chip-enable low, select codes 000, 011, 100 and 111 give pull_low_o = 0.
- R3: With chip-enable low and select 001, pull_low_o equals unlock_i, one clock after the inputs are applied.
- R4: With chip-enable low and select 010, pull_low_o is 1 exactly when the count-finished flag is set.
- R5: A cnt_done_i pulse sets the count-finished flag. A 0-to-1 transition of cnt_en_i clears it. When both occur in the same cycle, the flag ends cleared.
- R6: A rising edge of the synchronized chip-enable clears the count-finished flag. The flag stays cleared after chip-enable falls.
- R7: With chip-enable low, select 101 gives pull_low_o = NOT io_lvl_i[0] and select 110 gives pull_low_o = NOT io_lvl_i[1], when the corresponding io_is_out_i bit is 0 (pin is an input).
- R8: Under select 101 or 110, if the corresponding io_is_out_i bit is 1, pull_low_o = 0 whatever the pin level.
- R9: While synchronized chip-enable is high and rd_mode_i = 0, pull_low_o = 0 whatever the select code.
- R10: While synchronized chip-enable is high and rd_mode_i = 1, pull_low_o = NOT the rd_bit_i value captured at the last synchronized rising edge of ser_clk_i. The value is held between serial clock edges, whatever the select code.
- R11: ce_i and ser_clk_i reach the selection logic only through two-flop synchronizers. The output register adds one more clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 3 | Pin source select code |
| unlock_i | input | 1 | Loop unlock flag, 1 = unlocked |
| cnt_en_i | input | 1 | Frequency count enable; rising edge starts a count |
| cnt_done_i | input | 1 | One-cycle pulse at the end of a count |
| io_lvl_i | input | 2 | Levels of shared pins 1 and 2 (bit 0 = pin 1) |
| io_is_out_i | input | 2 | 1 = shared pin configured as output |
| ce_i | input | 1 | Serial chip-enable, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| rd_mode_i | input | 1 | 1 = serial read transfer, 0 = write transfer |
| rd_bit_i | input | 1 | Serial read data bit |
| pull_low_o | output | 1 | 1 = drive pad low, 0 = high impedance |

## Verification
The count-finished flag can be set and cleared in the same clock, when a cnt_done_i pulse coincides with a cnt_en_i rising edge. The bench drives both in one cycle under select 010. It then checks that the pin stays open, since the clear must win. A second collision puts a serial access on top of the count-finished indication. The bench judges it from the pin after chip-enable drops: the pin must be open, because the access cleared the flag. Random select, unlock and shared-pin patterns are compared against a bench-side reference function.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;
  localparam int SEL_W  = 3;
  localparam int NUM_IO = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE0  = 3'b000,
    SRC_UNLOCK = 3'b001,
    SRC_DONE   = 3'b010,
    SRC_NONE3  = 3'b011,
    SRC_NONE4  = 3'b100,
    SRC_IO0    = 3'b101,
    SRC_IO1    = 3'b110,
    SRC_NONE7  = 3'b111
  } pin_src_e;
endpackage

// File: rtl/status_sync.sv
module status_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/status_done_flag.sv
module status_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en_i,
  input  logic cnt_done_i,
  input  logic ce_rise_i,
  output logic done_o
);
  logic cnt_en_q;
  logic clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en_q <= 1'b0;
    else cnt_en_q <= cnt_en_i;
  end

  assign clr = (cnt_en_i & ~cnt_en_q) | ce_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else if (clr) done_o <= 1'b0;
    else if (cnt_done_i) done_o <= 1'b1;
  end

  // R5: clear wins over a coincident set
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && !cnt_en_q) |=> !done_o);
  // R6: serial access start clears the flag
  p_ce_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise_i |=> !done_o);
  // R5: set by the done pulse when nothing clears
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_done_i && !ce_rise_i && !(cnt_en_i && !cnt_en_q)) |=> done_o);
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import status_pin_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              unlock_i,
  input  logic              done_i,
  input  logic [NUM_IO-1:0] io_lvl_i,
  input  logic [NUM_IO-1:0] io_is_out_i,
  input  logic              ce_s_i,
  input  logic              rd_mode_i,
  input  logic              rd_q_i,
  output logic              pull_low_o
);
  pin_src_e src;
  assign src = pin_src_e'(sel_i);

  always_comb begin
    pull_low_o = 1'b0;
    if (ce_s_i) begin
      pull_low_o = rd_mode_i ? ~rd_q_i : 1'b0;
    end else begin
      unique case (src)
        SRC_UNLOCK: pull_low_o = unlock_i;
        SRC_DONE:   pull_low_o = done_i;
        SRC_IO0:    pull_low_o = ~io_is_out_i[0] & ~io_lvl_i[0];
        SRC_IO1:    pull_low_o = ~io_is_out_i[1] & ~io_lvl_i[1];
        default:    pull_low_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/status_pin_ctrl.sv
module status_pin_ctrl
  import status_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              unlock_i,
  input  logic              cnt_en_i,
  input  logic              cnt_done_i,
  input  logic [NUM_IO-1:0] io_lvl_i,
  input  logic [NUM_IO-1:0] io_is_out_i,
  input  logic              ce_i,
  input  logic              ser_clk_i,
  input  logic              rd_mode_i,
  input  logic              rd_bit_i,
  output logic              pull_low_o
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] async_in, sync_out;
  logic       ce_s, sclk_s, ce_d, sclk_d;
  logic       ce_rise, sclk_rise;
  logic       rd_q, done, pull_nxt;

  assign async_in = {ser_clk_i, ce_i};

  // R11: both serial controls cross through the synchronizer
  status_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_in), .q_o(sync_out)
  );
  assign ce_s   = sync_out[0];
  assign sclk_s = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
    end
  end
  assign ce_rise   = ce_s & ~ce_d;
  assign sclk_rise = sclk_s & ~sclk_d;

  // read bit held between serial clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else if (ce_s && rd_mode_i && sclk_rise) rd_q <= rd_bit_i;
  end

  status_done_flag u_flag (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .cnt_done_i(cnt_done_i),
    .ce_rise_i(ce_rise), .done_o(done)
  );

  status_pin_mux u_mux (
    .sel_i(sel_i), .unlock_i(unlock_i), .done_i(done), .io_lvl_i(io_lvl_i),
    .io_is_out_i(io_is_out_i), .ce_s_i(ce_s), .rd_mode_i(rd_mode_i),
    .rd_q_i(rd_q), .pull_low_o(pull_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_low_o <= 1'b0;
    else pull_low_o <= pull_nxt;
  end

  // R9: write transfer keeps the pin open
  p_write_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && !rd_mode_i) |=> !pull_low_o);
  // R10: read transfer shows the captured bit
  p_read_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && rd_mode_i) |=> (pull_low_o == !$past(rd_q)));
  // R8: an output-configured shared pin is never mirrored
  p_io_out_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && sel_i == SRC_IO0 && io_is_out_i[0]) |=> !pull_low_o);
  // R2: idle codes leave the pin open
  p_idle_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && (sel_i == 3'b000 || sel_i == 3'b011 || sel_i == 3'b100 || sel_i == 3'b111))
    |=> !pull_low_o);
  // R4: done-select mirrors the flag
  p_done_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && sel_i == SRC_DONE) |=> (pull_low_o == $past(done)));
endmodule

// File: tb/sim_status_pin_ctrl.sv
module sim_status_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic       unlock = 0, cnt_en = 0, cnt_done = 0;
  logic [1:0] io_lvl = '0, io_out = '0;
  logic       ce = 0, sclk = 0, rd_mode = 0, rd_bit = 0;
  logic       pull_low;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  status_pin_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .unlock_i(unlock),
    .cnt_en_i(cnt_en), .cnt_done_i(cnt_done), .io_lvl_i(io_lvl),
    .io_is_out_i(io_out), .ce_i(ce), .ser_clk_i(sclk), .rd_mode_i(rd_mode),
    .rd_bit_i(rd_bit), .pull_low_o(pull_low)
  );

  function automatic logic ref_pin(input logic [2:0] s, input logic ul, input logic dn,
                                   input logic [1:0] lv, input logic [1:0] od);
    case (s)
      3'b001:  return ul;
      3'b010:  return dn;
      3'b101:  return !od[0] && !lv[0];
      3'b110:  return !od[1] && !lv[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pull_low=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic done_m;
    void'($urandom(32'd1234));
    settle(3);
    rst_n = 1'b1;
    settle(1);
    chk(pull_low, 1'b0, "R1");

    // R2 idle codes with every other source active
    unlock = 1; io_lvl = 2'b00;
    foreach (sel[i]) ; // no-op keeps loop style simple
    for (int k = 0; k < 4; k++) begin
      sel = (k == 0) ? 3'b000 : (k == 1) ? 3'b011 : (k == 2) ? 3'b100 : 3'b111;
      settle(2);
      chk(pull_low, 1'b0, "R2");
    end

    // R3 unlock select
    sel = 3'b001; unlock = 1; settle(1); chk(pull_low, 1'b1, "R3");
    unlock = 0; settle(1); chk(pull_low, 1'b0, "R3");

    // R4/R5 done flag: start, finish, clear-on-restart
    sel = 3'b010; cnt_en = 1; settle(2);
    chk(pull_low, 1'b0, "R4");
    cnt_done = 1; settle(1); cnt_done = 0; settle(1);
    chk(pull_low, 1'b1, "R5");
    cnt_en = 0; settle(2); chk(pull_low, 1'b1, "R4");
    cnt_en = 1; settle(2); chk(pull_low, 1'b0, "R5");
    // R5 collision: done pulse in the same cycle as enable edge
    cnt_en = 0; settle(1);
    cnt_en = 1; cnt_done = 1; settle(1); cnt_done = 0; settle(2);
    chk(pull_low, 1'b0, "R5 clear wins");

    // R6 serial access clears the flag
    cnt_done = 1; settle(1); cnt_done = 0; settle(2);
    chk(pull_low, 1'b1, "R6 pre");
    rd_mode = 0; ce = 1; settle(6);
    chk(pull_low, 1'b0, "R9");
    ce = 0; settle(6);
    chk(pull_low, 1'b0, "R6");
    done_m = 1'b0;

    // R7/R8 shared pins
    sel = 3'b101; io_out = 2'b00; io_lvl = 2'b10; settle(2); chk(pull_low, 1'b1, "R7");
    io_lvl = 2'b01; settle(2); chk(pull_low, 1'b0, "R7");
    sel = 3'b110; io_lvl = 2'b01; settle(2); chk(pull_low, 1'b1, "R7");
    io_out = 2'b10; settle(2); chk(pull_low, 1'b0, "R8");
    sel = 3'b101; io_out = 2'b01; io_lvl = 2'b00; settle(2); chk(pull_low, 1'b0, "R8");

    // R11 latency: ce takes effect only after the synchronizer
    sel = 3'b001; unlock = 1; settle(2);
    ce = 1; rd_mode = 0; settle(1);
    chk(pull_low, 1'b1, "R11 not yet");
    settle(3);
    chk(pull_low, 1'b0, "R11 after sync");

    // R10 read transfer, bits captured on serial clock edges
    rd_mode = 1;
    for (int b = 0; b < 6; b++) begin
      logic bitv;
      bitv = (b % 2 == 0) ? 1'b0 : 1'b1;
      rd_bit = bitv; settle(2);
      sclk = 1; settle(6);
      chk(pull_low, !bitv, "R10");
      rd_bit = !bitv; sclk = 0; settle(6);
      chk(pull_low, !bitv, "R10 hold");
    end
    ce = 0; rd_mode = 0; settle(6);

    // random patterns against the reference function
    for (int n = 0; n < 300; n++) begin
      sel = 3'($urandom); unlock = 1'($urandom);
      io_lvl = 2'($urandom); io_out = 2'($urandom);
      settle(2);
      chk(pull_low, ref_pin(sel, unlock, done_m, io_lvl, io_out), "R2/R3/R7/R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule